// File: doc/BRIEF.md
# Copy Engine Register Front End

This block is the memory-mapped register layer that sits in front of a multi-channel memory copy engine. A simple request bus presents an address, an access size code, write data and separate write and read strobes; the block answers with combinational read data and applies every register side effect on the clock edge that ends the access. The low 128 bytes of the space hold device-wide registers. Above them, the space is cut into consecutive 128-byte windows, one per channel, and the block works out which channel and which local offset an access targets.

Each channel window holds a control word, a status word supplied by the channel's own sequencer, two 64-bit pointers (descriptor chain and completion target) that software may write whole or in 32-bit halves, a command byte and an error word. A write to the command byte reaches the channel as a single-cycle pulse carrying the byte. Accesses that hit no register, use a size that register does not take, or name a channel beyond the configured count are flagged through a sticky error output.

Top module: `cpe_reg_front`

## Requirements
- R1: An address below 0x80 selects the device-wide registers at that offset; an address A of 0x80 or more selects channel (A-0x80)/0x80 at local offset (A-0x80) mod 0x80. Device-wide offsets: 0x00 channel count (1 byte), 0x01 transfer size exponent (1 byte), 0x03 interrupt control (1 byte), 0x04 attention (4 bytes). Channel offsets: 0x00 control (2 bytes), 0x08 status (8 bytes), 0x10/0x14 chain pointer low/high, 0x18/0x1C completion pointer low/high, 0x20 command (1 byte), 0x24 error (4 bytes). Size code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes.
- R2: An access to an unlisted offset, with a size the register does not accept, or to a channel index at or above NCH, returns zero on a read, changes no register and sets dec_err_o, which then stays high until reset.
- R3: The channel-count register reads NCH and the transfer size exponent reads the index of the highest set bit of XFER_MAX; writes to either leave them unchanged.
- R4: The attention register accumulates bits raised on attn_set_i; a read returns its value and clears it on that edge (bits raised in the same cycle survive); writes have no effect.
- R5: The interrupt control register reads the enable in bit 0; a write loads the enable from bit 0 of the data; a read clears the enable after returning it. intr_en_o shows the enable.
- R6: The channel control word (2-byte access only) is replaced by a write, except bit 0 (interrupt disable), which is cleared when the written bit 0 is one and otherwise kept; a read returns the word and then sets bit 8 (in use).
- R7: The chain and completion pointers accept 8-byte reads and writes of the whole value, or 4-byte accesses at the low offset (bits 31:0) and at the high offset (bits 63:32); a half write leaves the other half untouched.
- R8: The 4-byte error word clears each bit written as one and keeps the others; bits raised on the channel's slice of err_set_i are OR-ed in on every edge after the clear.
- R9: The 8-byte status read returns the channel's slice of stat_i; writes to it have no effect.
- R10: A 1-byte command write to channel c raises cmd_pulse_o[c] for exactly the next cycle with cmd_byte_o holding the written byte; the command register reads zero.
- R11: After reset all control words, pointers, error words, the attention word, the enable, the decode error flag and the command outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 64 | Write data, right aligned |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 64 | Read data, zero extended |
| attn_set_i | input | 32 | Attention bits to raise |
| stat_i | input | NCH*64 | Per-channel status words from the sequencers |
| err_set_i | input | NCH*32 | Per-channel error bits to raise |
| intr_en_o | output | 1 | Master interrupt enable |
| dec_err_o | output | 1 | Sticky decode error |
| cmd_pulse_o | output | NCH | One-cycle command strobe per channel |
| cmd_byte_o | output | 8 | Command byte accompanying the strobe |
| ctrl_o | output | NCH*16 | Per-channel control words |
| chain_o | output | NCH*64 | Per-channel chain pointers |
| cmpl_o | output | NCH*64 | Per-channel completion pointers |

## Verification
The assertions take for granted that the requester never raises the write and read strobes in the same cycle, since the register side effects for a combined access are not defined; one property checks this contract at the inputs. The stimulus respects it by issuing exactly one operation per cycle from a single task, mixing directed sequences on every register with a long run of random legal accesses while attention and error bits are raised at random in the same cycles, and it leaves the illegal accesses to the end because the error flag they set is sticky.

// File: rtl/cpe_pkg.sv
package cpe_pkg;

   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } acc_size_e;

   localparam int WIN_BITS = 7;

   // device-wide offsets
   localparam logic [6:0] G_NCHAN = 7'h00;
   localparam logic [6:0] G_XCAP  = 7'h01;
   localparam logic [6:0] G_IRQ   = 7'h03;
   localparam logic [6:0] G_ATTN  = 7'h04;

   // per-channel offsets
   localparam logic [6:0] C_CTRL   = 7'h00;
   localparam logic [6:0] C_STAT   = 7'h08;
   localparam logic [6:0] C_CHAIN  = 7'h10;
   localparam logic [6:0] C_CHAINH = 7'h14;
   localparam logic [6:0] C_CMPL   = 7'h18;
   localparam logic [6:0] C_CMPLH  = 7'h1C;
   localparam logic [6:0] C_CMD    = 7'h20;
   localparam logic [6:0] C_ERR    = 7'h24;

   localparam int CTRL_IDIS_BIT = 0;
   localparam int CTRL_USE_BIT  = 8;

endpackage

// File: rtl/cpe_addr_dec.sv
module cpe_addr_dec #(
   parameter int ADDR_W = 16,
   parameter int NCH    = 4,
   localparam int IDX_W = ADDR_W - cpe_pkg::WIN_BITS
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              is_glob,
   output logic [6:0]        off,
   output logic [IDX_W-1:0]  idx,
   output logic              idx_ok
);
   logic [ADDR_W-1:0] rel;

   always_comb begin
      rel     = addr - ADDR_W'(128);
      is_glob = (addr[ADDR_W-1:cpe_pkg::WIN_BITS] == '0);
      off     = addr[6:0];
      idx     = rel[ADDR_W-1:cpe_pkg::WIN_BITS];
      idx_ok  = !is_glob && (32'(idx) < NCH);
   end
endmodule

// File: rtl/cpe_glob_regs.sv
module cpe_glob_regs
   import cpe_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int XFER_MAX = 4096,
   localparam logic [7:0] XCAP = 8'($clog2(XFER_MAX + 1) - 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic [6:0]  off,
   input  logic [1:0]  size,
   input  logic        wr_bit,
   input  logic        we,
   input  logic        re,
   input  logic [31:0] attn_set,
   output logic [63:0] rdata,
   output logic        hit,
   output logic        intr_en
);
   logic [31:0] attn_q;
   logic        rd_attn, rd_irq, wr_irq;

   always_comb begin
      hit     = 1'b0;
      rdata   = '0;
      rd_attn = 1'b0;
      rd_irq  = 1'b0;
      wr_irq  = 1'b0;
      if (sel) begin
         case (off)
            G_NCHAN: if (size == SZ_B) begin
               hit   = 1'b1;
               rdata = 64'(NCH);
            end
            G_XCAP: if (size == SZ_B) begin
               hit   = 1'b1;
               rdata = 64'(XCAP);
            end
            G_IRQ: if (size == SZ_B) begin
               hit    = 1'b1;
               rdata  = 64'(intr_en);
               rd_irq = re;
               wr_irq = we;
            end
            G_ATTN: if (size == SZ_W) begin
               hit     = 1'b1;
               rdata   = 64'(attn_q);
               rd_attn = re;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attn_q  <= '0;
         intr_en <= 1'b0;
      end else begin
         attn_q <= (rd_attn ? 32'd0 : attn_q) | attn_set;
         if (wr_irq)      intr_en <= wr_bit;
         else if (rd_irq) intr_en <= 1'b0;
      end
   end
endmodule

// File: rtl/cpe_addr64.sv
module cpe_addr64 #(
   parameter int HALF = 32,
   localparam int FULL = 2 * HALF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_full,
   input  logic            wr_lo,
   input  logic            wr_hi,
   input  logic [FULL-1:0] d,
   output logic [FULL-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (wr_full) q <= d;
      else if (wr_lo)   q[HALF-1:0] <= d[HALF-1:0];
      else if (wr_hi)   q[FULL-1:HALF] <= d[HALF-1:0];
   end
endmodule

// File: rtl/cpe_chan_regs.sv
module cpe_chan_regs
   import cpe_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel,
   input  logic [6:0]  off,
   input  logic [1:0]  size,
   input  logic [63:0] wdata,
   input  logic        we,
   input  logic        re,
   input  logic [63:0] stat_i,
   input  logic [31:0] err_set,
   output logic [63:0] rdata,
   output logic        hit,
   output logic        cmd_pulse,
   output logic [7:0]  cmd_byte,
   output logic [15:0] ctrl,
   output logic [63:0] chain,
   output logic [63:0] cmpl
);
   logic [31:0] err_q;
   logic w_ctrl, r_ctrl, w_err, w_cmd;
   logic wf_ch, wl_ch, wh_ch, wf_cp, wl_cp, wh_cp;

   always_comb begin
      hit = 1'b0;  rdata = '0;
      w_ctrl = 1'b0; r_ctrl = 1'b0; w_err = 1'b0; w_cmd = 1'b0;
      wf_ch = 1'b0; wl_ch = 1'b0; wh_ch = 1'b0;
      wf_cp = 1'b0; wl_cp = 1'b0; wh_cp = 1'b0;
      if (sel) begin
         case (off)
            C_CTRL: if (size == SZ_H) begin
               hit = 1'b1; rdata = 64'(ctrl); w_ctrl = we; r_ctrl = re;
            end
            C_STAT: if (size == SZ_D) begin
               hit = 1'b1; rdata = stat_i;
            end
            C_CHAIN: if (size == SZ_D) begin
               hit = 1'b1; rdata = chain; wf_ch = we;
            end else if (size == SZ_W) begin
               hit = 1'b1; rdata = 64'(chain[31:0]); wl_ch = we;
            end
            C_CHAINH: if (size == SZ_W) begin
               hit = 1'b1; rdata = 64'(chain[63:32]); wh_ch = we;
            end
            C_CMPL: if (size == SZ_D) begin
               hit = 1'b1; rdata = cmpl; wf_cp = we;
            end else if (size == SZ_W) begin
               hit = 1'b1; rdata = 64'(cmpl[31:0]); wl_cp = we;
            end
            C_CMPLH: if (size == SZ_W) begin
               hit = 1'b1; rdata = 64'(cmpl[63:32]); wh_cp = we;
            end
            C_CMD: if (size == SZ_B) begin
               hit = 1'b1; w_cmd = we;
            end
            C_ERR: if (size == SZ_W) begin
               hit = 1'b1; rdata = 64'(err_q); w_err = we;
            end
            default: ;
         endcase
      end
   end

   cpe_addr64 u_chain (
      .clk(clk), .rst_n(rst_n), .wr_full(wf_ch), .wr_lo(wl_ch), .wr_hi(wh_ch),
      .d(wdata), .q(chain)
   );

   cpe_addr64 u_cmpl (
      .clk(clk), .rst_n(rst_n), .wr_full(wf_cp), .wr_lo(wl_cp), .wr_hi(wh_cp),
      .d(wdata), .q(cmpl)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         err_q     <= '0;
         cmd_pulse <= 1'b0;
         cmd_byte  <= '0;
      end else begin
         if (w_ctrl) begin
            ctrl <= wdata[15:0];
            ctrl[CTRL_IDIS_BIT] <= wdata[CTRL_IDIS_BIT] ? 1'b0 : ctrl[CTRL_IDIS_BIT];
         end else if (r_ctrl) begin
            ctrl[CTRL_USE_BIT] <= 1'b1;
         end
         err_q     <= (w_err ? (err_q & ~wdata[31:0]) : err_q) | err_set;
         cmd_pulse <= w_cmd;
         cmd_byte  <= w_cmd ? wdata[7:0] : 8'd0;
      end
   end
endmodule

// File: rtl/cpe_reg_front.sv
module cpe_reg_front #(
   parameter int NCH      = 4,
   parameter int ADDR_W   = 16,
   parameter int XFER_MAX = 4096,
   localparam int IDX_W   = ADDR_W - cpe_pkg::WIN_BITS
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [1:0]          bus_size,
   input  logic [63:0]         bus_wdata,
   input  logic                bus_we,
   input  logic                bus_re,
   output logic [63:0]         bus_rdata,
   input  logic [31:0]         attn_set_i,
   input  logic [NCH*64-1:0]   stat_i,
   input  logic [NCH*32-1:0]   err_set_i,
   output logic                intr_en_o,
   output logic                dec_err_o,
   output logic [NCH-1:0]      cmd_pulse_o,
   output logic [7:0]          cmd_byte_o,
   output logic [NCH*16-1:0]   ctrl_o,
   output logic [NCH*64-1:0]   chain_o,
   output logic [NCH*64-1:0]   cmpl_o
);
   generate
      if (NCH < 1 || NCH > 64) begin : g_bad_nch
         $error("cpe_reg_front: NCH must lie in 1..64");
      end
      if ((NCH + 1) * 128 > (1 << ADDR_W)) begin : g_bad_aw
         $error("cpe_reg_front: ADDR_W too small for NCH windows");
      end
      if (XFER_MAX < 1) begin : g_bad_xfer
         $error("cpe_reg_front: XFER_MAX must be positive");
      end
   endgenerate

   logic             is_glob, idx_ok;
   logic [6:0]       off;
   logic [IDX_W-1:0] idx;

   cpe_addr_dec #(.ADDR_W(ADDR_W), .NCH(NCH)) u_dec (
      .addr(bus_addr), .is_glob(is_glob), .off(off), .idx(idx), .idx_ok(idx_ok)
   );

   logic [63:0] g_rdata;
   logic        g_hit;

   cpe_glob_regs #(.NCH(NCH), .XFER_MAX(XFER_MAX)) u_glob (
      .clk(clk), .rst_n(rst_n), .sel(is_glob), .off(off), .size(bus_size),
      .wr_bit(bus_wdata[0]), .we(bus_we), .re(bus_re), .attn_set(attn_set_i),
      .rdata(g_rdata), .hit(g_hit), .intr_en(intr_en_o)
   );

   logic [63:0] c_rdata [NCH];
   logic [7:0]  c_byte  [NCH];
   logic [NCH-1:0] c_hit;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      cpe_chan_regs u_ch (
         .clk(clk), .rst_n(rst_n),
         .sel(idx_ok && (idx == IDX_W'(i))),
         .off(off), .size(bus_size), .wdata(bus_wdata), .we(bus_we), .re(bus_re),
         .stat_i(stat_i[i*64 +: 64]), .err_set(err_set_i[i*32 +: 32]),
         .rdata(c_rdata[i]), .hit(c_hit[i]),
         .cmd_pulse(cmd_pulse_o[i]), .cmd_byte(c_byte[i]),
         .ctrl(ctrl_o[i*16 +: 16]), .chain(chain_o[i*64 +: 64]),
         .cmpl(cmpl_o[i*64 +: 64])
      );
   end

   logic hit_any;

   always_comb begin
      bus_rdata  = g_rdata;
      cmd_byte_o = '0;
      for (int i = 0; i < NCH; i++) begin
         bus_rdata  = bus_rdata | c_rdata[i];
         cmd_byte_o = cmd_byte_o | c_byte[i];
      end
      hit_any = g_hit | (|c_hit);
      if (!hit_any) bus_rdata = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             dec_err_o <= 1'b0;
      else if ((bus_we || bus_re) && !hit_any) dec_err_o <= 1'b1;
   end
endmodule

// File: rtl/cpe_reg_chk.sv
module cpe_reg_chk #(
   parameter int NCH    = 4,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic              bus_we,
   input logic              bus_re,
   input logic [63:0]       bus_rdata,
   input logic              intr_en_o,
   input logic              dec_err_o,
   input logic [NCH-1:0]    cmd_pulse_o,
   input logic [NCH*64-1:0] chain_o
);
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'((NCH + 1) * 128);

   // bus contract: one operation per cycle (R1)
   p_one_op_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));

   p_derr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      dec_err_o |=> dec_err_o);

   p_oor_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr >= TOP_ADDR) |-> (bus_rdata == 64'd0));

   p_oor_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && bus_addr >= TOP_ADDR) |=> dec_err_o);

   p_irq_rdclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re && !bus_we && bus_addr == ADDR_W'(3) && bus_size == 2'd0) |=> !intr_en_o);

   p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(chain_o));

   p_cmd_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_pulse_o));

   p_cmd_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> (cmd_pulse_o == '0));
endmodule

bind cpe_reg_front cpe_reg_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
   .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
   .intr_en_o(intr_en_o), .dec_err_o(dec_err_o),
   .cmd_pulse_o(cmd_pulse_o), .chain_o(chain_o)
);

// File: tb/test_cpe_reg_front.sv
module test_cpe_reg_front;
   localparam int NCH = 4;
   localparam int AW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [AW-1:0]     b_addr = '0;
   logic [1:0]        b_size = '0;
   logic [63:0]       b_wdata = '0;
   logic              b_we = 1'b0, b_re = 1'b0;
   logic [63:0]       b_rdata;
   logic [31:0]       attn_set = '0;
   logic [NCH*64-1:0] stat_in;
   logic [NCH*32-1:0] err_set = '0;
   logic              intr_en, dec_err;
   logic [NCH-1:0]    cmd_pulse;
   logic [7:0]        cmd_byte;
   logic [NCH*16-1:0] ctrl;
   logic [NCH*64-1:0] chain, cmpl;

   cpe_reg_front #(.NCH(NCH), .ADDR_W(AW), .XFER_MAX(4096)) i_cpe_reg_front (
      .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_size(b_size),
      .bus_wdata(b_wdata), .bus_we(b_we), .bus_re(b_re), .bus_rdata(b_rdata),
      .attn_set_i(attn_set), .stat_i(stat_in), .err_set_i(err_set),
      .intr_en_o(intr_en), .dec_err_o(dec_err), .cmd_pulse_o(cmd_pulse),
      .cmd_byte_o(cmd_byte), .ctrl_o(ctrl), .chain_o(chain), .cmpl_o(cmpl)
   );

   int total = 0, bad = 0;
   bit done = 0;

   // reference model state
   logic [15:0] m_ctrl [NCH];
   logic [63:0] m_chain [NCH];
   logic [63:0] m_cmpl [NCH];
   logic [31:0] m_err [NCH];
   logic [31:0] m_attn;
   logic        m_ien, m_derr;
   logic [NCH-1:0] m_cmdp;
   logic [7:0]  m_cmdb;
   int          mch, moff;
   bit          mok;

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   function automatic bit legal(logic [AW-1:0] a, logic [1:0] s);
      int c, o;
      if (a < 128) begin
         case (int'(a))
            0, 1, 3: return s == 2'd0;
            4:       return s == 2'd2;
            default: return 1'b0;
         endcase
      end
      c = (int'(a) - 128) / 128;
      o = (int'(a) - 128) % 128;
      if (c >= NCH) return 1'b0;
      case (o)
         0:      return s == 2'd1;
         8:      return s == 2'd3;
         16, 24: return s == 2'd3 || s == 2'd2;
         20, 28: return s == 2'd2;
         32:     return s == 2'd0;
         36:     return s == 2'd2;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [63:0] mread(logic [AW-1:0] a, logic [1:0] s);
      int c, o;
      if (!legal(a, s)) return 64'd0;
      if (a < 128) begin
         case (int'(a))
            0: return 64'd4;
            1: return 64'd12;
            3: return {63'd0, m_ien};
            default: return {32'd0, m_attn};
         endcase
      end
      c = (int'(a) - 128) / 128;
      o = (int'(a) - 128) % 128;
      case (o)
         0:  return {48'd0, m_ctrl[c]};
         8:  return stat_in[c*64 +: 64];
         16: return (s == 2'd3) ? m_chain[c] : {32'd0, m_chain[c][31:0]};
         20: return {32'd0, m_chain[c][63:32]};
         24: return (s == 2'd3) ? m_cmpl[c] : {32'd0, m_cmpl[c][31:0]};
         28: return {32'd0, m_cmpl[c][63:32]};
         36: return {32'd0, m_err[c]};
         default: return 64'd0;
      endcase
   endfunction

   // reference model, advanced on each rising edge from the driven inputs
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_ctrl[c] = '0; m_chain[c] = '0; m_cmpl[c] = '0; m_err[c] = '0;
         end
         m_attn = '0; m_ien = 0; m_derr = 0; m_cmdp = '0; m_cmdb = '0;
      end else begin
         m_cmdp = '0;
         m_cmdb = '0;
         mok = legal(b_addr, b_size);
         if ((b_we || b_re) && !mok) m_derr = 1;
         if (mok && b_addr < 128) begin
            if (b_re && b_addr == 4) m_attn = '0;
            if (b_re && b_addr == 3) m_ien = 0;
            if (b_we && b_addr == 3) m_ien = b_wdata[0];
         end
         m_attn = m_attn | attn_set;
         if (mok && b_addr >= 128) begin
            mch  = (int'(b_addr) - 128) / 128;
            moff = (int'(b_addr) - 128) % 128;
            case (moff)
               0: if (b_we) m_ctrl[mch] = {b_wdata[15:1], b_wdata[0] ? 1'b0 : m_ctrl[mch][0]};
                  else if (b_re) m_ctrl[mch][8] = 1'b1;
               16: if (b_we) m_chain[mch] = (b_size == 2'd3) ? b_wdata
                                            : {m_chain[mch][63:32], b_wdata[31:0]};
               20: if (b_we) m_chain[mch][63:32] = b_wdata[31:0];
               24: if (b_we) m_cmpl[mch] = (b_size == 2'd3) ? b_wdata
                                           : {m_cmpl[mch][63:32], b_wdata[31:0]};
               28: if (b_we) m_cmpl[mch][63:32] = b_wdata[31:0];
               32: if (b_we) begin m_cmdp[mch] = 1'b1; m_cmdb = b_wdata[7:0]; end
               36: if (b_we) m_err[mch] = m_err[mch] & ~b_wdata[31:0];
               default: ;
            endcase
         end
         for (int c = 0; c < NCH; c++) m_err[c] = m_err[c] | err_set[c*32 +: 32];
      end
   end

   // registered outputs compared against the model on every falling edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R5", "intr_en", 64'(intr_en), 64'(m_ien));
         chk("R2", "dec_err", 64'(dec_err), 64'(m_derr));
         chk("R10", "cmd_pulse", 64'(cmd_pulse), 64'(m_cmdp));
         chk("R10", "cmd_byte", 64'(cmd_byte), 64'(m_cmdb));
         for (int c = 0; c < NCH; c++) begin
            chk("R6", "ctrl", 64'(ctrl[c*16 +: 16]), 64'(m_ctrl[c]));
            chk("R7", "chain", chain[c*64 +: 64], m_chain[c]);
            chk("R7", "cmpl", cmpl[c*64 +: 64], m_cmpl[c]);
         end
      end
   end

   task automatic op(bit w, bit r, logic [AW-1:0] a, logic [1:0] s, logic [63:0] d,
                     string tag, logic [31:0] as = '0, logic [NCH*32-1:0] es = '0);
      @(negedge clk);
      b_we = w; b_re = r; b_addr = a; b_size = s; b_wdata = d;
      attn_set = as; err_set = es;
      #1;
      if (r) chk(tag, $sformatf("rdata@%h", a), b_rdata, mread(a, s));
   endtask

   task automatic idle();
      @(negedge clk);
      b_we = 0; b_re = 0; attn_set = '0; err_set = '0;
   endtask

   function automatic logic [AW-1:0] cb(int c, int o);
      return AW'(128 + 128 * c + o);
   endfunction

   initial begin
      for (int c = 0; c < NCH; c++) stat_in[c*64 +: 64] = 64'hC0DE_5A00_0000_0000 | 64'(c);
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", "intr_en", 64'(intr_en), 0);
      chk("R11", "dec_err", 64'(dec_err), 0);
      chk("R11", "cmd_pulse", 64'(cmd_pulse), 0);
      chk("R11", "ctrl", 64'(ctrl), 0);
      chk("R11", "chain", 64'(chain != '0), 0);
      chk("R11", "cmpl", 64'(cmpl != '0), 0);
      rst_n = 1;

      // R3: constant registers, writes ignored
      op(0, 1, 16'h0000, 2'd0, 0, "R3");
      op(0, 1, 16'h0001, 2'd0, 0, "R3");
      op(1, 0, 16'h0000, 2'd0, 64'hFF, "R3");
      op(1, 0, 16'h0001, 2'd0, 64'hFF, "R3");
      op(0, 1, 16'h0000, 2'd0, 0, "R3");
      op(0, 1, 16'h0001, 2'd0, 0, "R3");
      // R4: attention accumulate, read-to-clear, write ignored
      op(0, 0, 16'h0000, 2'd0, 0, "R4", 32'h5);
      op(0, 0, 16'h0000, 2'd0, 0, "R4", 32'h100);
      op(1, 0, 16'h0004, 2'd2, 64'h0, "R4");
      op(0, 1, 16'h0004, 2'd2, 0, "R4");
      op(0, 1, 16'h0004, 2'd2, 0, "R4", 32'h8);
      op(0, 1, 16'h0004, 2'd2, 0, "R4");
      op(0, 1, 16'h0004, 2'd2, 0, "R4");
      // R5: interrupt enable
      op(1, 0, 16'h0003, 2'd0, 64'h3, "R5");
      op(0, 1, 16'h0003, 2'd0, 0, "R5");
      op(0, 1, 16'h0003, 2'd0, 0, "R5");
      op(1, 0, 16'h0003, 2'd0, 64'h2, "R5");
      // R6: control word
      op(1, 0, cb(2, 0), 2'd1, 64'h0103, "R6");
      op(0, 1, cb(2, 0), 2'd1, 0, "R6");
      op(1, 0, cb(2, 0), 2'd1, 64'h00F0, "R6");
      op(0, 1, cb(2, 0), 2'd1, 0, "R6");
      op(0, 1, cb(2, 0), 2'd1, 0, "R6");
      // R7: pointers full and half writes
      op(1, 0, cb(1, 16), 2'd3, 64'h1122_3344_5566_7788, "R7");
      op(1, 0, cb(1, 16), 2'd2, 64'hFFFF_FFFF_AAAA_AAAA, "R7");
      op(0, 1, cb(1, 16), 2'd3, 0, "R7");
      op(1, 0, cb(1, 20), 2'd2, 64'h0000_0000_BBBB_BBBB, "R7");
      op(0, 1, cb(1, 16), 2'd3, 0, "R7");
      op(0, 1, cb(1, 16), 2'd2, 0, "R7");
      op(0, 1, cb(1, 20), 2'd2, 0, "R7");
      op(1, 0, cb(3, 24), 2'd3, 64'h0123_4567_89AB_CDEF, "R7");
      op(1, 0, cb(3, 28), 2'd2, 64'h0000_0000_DEAD_BEEF, "R7");
      op(0, 1, cb(3, 24), 2'd3, 0, "R7");
      op(0, 1, cb(3, 28), 2'd2, 0, "R7");
      // R10: command pulse
      op(1, 0, cb(0, 32), 2'd0, 64'h21, "R10");
      op(0, 1, cb(0, 32), 2'd0, 0, "R10");
      op(1, 0, cb(3, 32), 2'd0, 64'h7E, "R10");
      op(1, 0, cb(1, 32), 2'd0, 64'h01, "R10");
      idle();
      // R8: error raise and write-one-to-clear
      op(0, 0, 16'h0000, 2'd0, 0, "R8", 0, {32'd0, 32'd0, 32'h0000_F0F0, 32'd0});
      op(1, 0, cb(1, 36), 2'd2, 64'h00F0, "R8");
      op(0, 1, cb(1, 36), 2'd2, 0, "R8");
      op(1, 0, cb(1, 36), 2'd2, 64'hF000, "R8", 0, {32'd0, 32'd0, 32'h0000_0001, 32'd0});
      op(0, 1, cb(1, 36), 2'd2, 0, "R8");
      // R9: status mirrors the channel, write ignored
      op(0, 1, cb(2, 8), 2'd3, 0, "R9");
      op(1, 0, cb(2, 8), 2'd3, 64'h0, "R9");
      op(0, 1, cb(2, 8), 2'd3, 0, "R9");
      op(0, 1, cb(0, 8), 2'd3, 0, "R9");

      // R1: random legal traffic across every window, with side inputs
      for (int k = 0; k < 400; k++) begin
         int pick, c;
         logic [AW-1:0] a;
         logic [1:0] s;
         bit w;
         pick = $urandom_range(0, 11);
         c = $urandom_range(0, NCH - 1);
         case (pick)
            0:  begin a = 16'h0003; s = 2'd0; end
            1:  begin a = 16'h0004; s = 2'd2; end
            2:  begin a = cb(c, 0);  s = 2'd1; end
            3:  begin a = cb(c, 8);  s = 2'd3; end
            4:  begin a = cb(c, 16); s = 2'd3; end
            5:  begin a = cb(c, 16); s = 2'd2; end
            6:  begin a = cb(c, 20); s = 2'd2; end
            7:  begin a = cb(c, 24); s = 2'd3; end
            8:  begin a = cb(c, 28); s = 2'd2; end
            9:  begin a = cb(c, 32); s = 2'd0; end
            10: begin a = cb(c, 36); s = 2'd2; end
            default: begin a = 16'h0001; s = 2'd0; end
         endcase
         w = $urandom_range(0, 1);
         op(w, !w, a, s, {$urandom, $urandom}, "R1",
            ($urandom_range(0, 3) == 0) ? $urandom : 32'd0,
            ($urandom_range(0, 3) == 0) ? {$urandom, $urandom, $urandom, $urandom} : '0);
      end
      idle();

      // R2: illegal accesses, last because the flag is sticky
      op(1, 0, cb(2, 0), 2'd2, 64'hFFFF, "R2");
      op(0, 1, cb(2, 0), 2'd2, 0, "R2");
      op(0, 1, cb(4, 0), 2'd1, 0, "R2");
      op(1, 0, cb(5, 16), 2'd3, 64'h55, "R2");
      op(0, 1, 16'h0002, 2'd0, 0, "R2");
      op(0, 1, cb(0, 4), 2'd2, 0, "R2");
      idle();
      idle();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL R1 watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule